// File: doc/BRIEF.md
# Polled Byte-Port Packet Interface

This block is a network interface peripheral that a host drives by polling a small window of 32-bit registers. It buffers one incoming frame and one outgoing frame, each in its own byte-wide on-chip memory sized for a full 1514-byte frame. The host takes a received frame out one byte per read of a data register. It assembles a frame to send by programming a length and then writing the bytes one at a time to a second data register.

On the network side, frames arrive on a byte stream with valid, last and ready. Completed transmit frames leave on a byte stream of the same kind. A single level interrupt is raised while any completion or self-test flag is pending. A busy flag blocks new reception until the host has acknowledged every flag. Writing the self-test bit of the interrupt register returns the whole block to its reset state and leaves the test flag raised, so software can check that the interrupt line works.

Top module: `pktport`

## Requirements
- R1: Decode uses the 6-bit byte offset `host_addr`: 0x00 and 0x04 read the constants 0x42595445 and 0x50525431, 0x08 busy (bit 0), 0x0c receive count, 0x10 transmit count, 0x14 interrupt control, 0x18 reads 0, 0x1c receive data and 0x20 transmit data. The transmit data offset and any unlisted offset read 0. Writes to offsets 0x00 to 0x0c, 0x18 and 0x1c change nothing. Read data appears on `host_rdata` in the cycle after the access and holds until the next read.
- R2: After reset, busy reads 1, both counts read 0, interrupt control reads 0, `irq` is 0 and `rx_ready` is 0.
- R3: Interrupt control bit 0 is transmit done, bit 1 is receive done and bit 31 is test. `irq` is high exactly while any of these bits is set.
- R4: A write to interrupt control clears transmit done if data bit 0 is set. Otherwise it clears receive done if data bit 1 is set. After the write, busy equals 1 if any flag is still set and 0 otherwise, so a write of 0 only recomputes busy.
- R5: A write to interrupt control with data bits 0 and 1 clear and bit 31 set resets every counter, pointer and flag and stops any outgoing frame. It then sets the test flag, which also leaves busy at 1. A read of interrupt control returns the current value and then clears the test flag.
- R6: At the start of a frame, `rx_ready` is high only when busy is 0 and the receive count is below 1514. Once a first byte is taken, `rx_ready` stays high through the byte marked last.
- R7: Taking a frame's first byte sets busy and zeroes the read pointer. The receive count then equals the number of bytes taken, saturating at 1514. Receive done is set in the cycle after the last byte is taken.
- R8: A read of receive data while the count is nonzero and no frame is arriving returns the next stored byte in bits 7:0, then advances the pointer and decrements the count. Any other read of it returns 0 and changes nothing.
- R9: A write to transmit count loads the value if it is at most 1514 and loads 0 otherwise. The write also restarts the written-byte counter at 0.
- R10: A write to transmit data stores bits 7:0 and advances the written counter. The write that makes the counter equal the transmit count starts the frame, clears both counters, sets transmit done and sets busy.
- R11: An outgoing frame is presented on `tx_data` from its first byte, with `tx_valid` high from the cycle after the completing write. Each byte advances when `tx_ready` is high and holds while it is low. `tx_last` marks the final byte. Transmit data writes made while a frame is going out, or while the transmit count is 0, are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_sel | input | 1 | Register access strobe, one access per cycle |
| host_wr | input | 1 | 1 for write, 0 for read |
| host_addr | input | 6 | Byte offset in the register window |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, registered |
| rx_valid | input | 1 | Incoming byte valid |
| rx_data | input | 8 | Incoming byte |
| rx_last | input | 1 | Incoming byte ends the frame |
| rx_ready | output | 1 | Block takes the incoming byte |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_data | output | 8 | Outgoing byte |
| tx_last | output | 1 | Outgoing byte ends the frame |
| tx_ready | input | 1 | Sink takes the outgoing byte |
| irq | output | 1 | Level interrupt |

## Verification
Every register side effect and every read result lands at the clock edge that samples the access. The bench therefore drives an access on a falling edge and reads `host_rdata`, `irq` and the stream outputs on the next falling edge, one cycle later. Receive done and the interrupt follow the edge that takes the last byte, and `tx_valid` rises after the edge of the completing data write. `rx_ready` and `tx_last` are combinational from registered state and the bench reads them mid-cycle before the edge that uses them. The saturation boundary at 1514 bytes, the write priority and the writes ignored during streaming are each observed through later reads or through the bytes that come out.

// File: rtl/pktport_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the polled byte-port packet interface.
// Assumes a 6-bit byte-offset register window with 32-bit data.
package pktport_pkg;
    localparam logic [5:0] OFS_ID0   = 6'h00;
    localparam logic [5:0] OFS_ID1   = 6'h04;
    localparam logic [5:0] OFS_BUSY  = 6'h08;
    localparam logic [5:0] OFS_RXCNT = 6'h0c;
    localparam logic [5:0] OFS_TXCNT = 6'h10;
    localparam logic [5:0] OFS_ICTL  = 6'h14;
    localparam logic [5:0] OFS_INFO  = 6'h18;
    localparam logic [5:0] OFS_RXDAT = 6'h1c;
    localparam logic [5:0] OFS_TXDAT = 6'h20;

    localparam logic [31:0] ID_WORD0 = 32'h4259_5445;
    localparam logic [31:0] ID_WORD1 = 32'h5052_5431;

    // Pending flags; packed as test, receive done, transmit done.
    typedef struct packed {
        logic test;
        logic rxd;
        logic txd;
    } ictl_t;

    // Map the flag set onto the 32-bit register layout.
    function automatic logic [31:0] ictl_word(input ictl_t f);
        return {f.test, 29'd0, f.rxd, f.txd};
    endfunction
endpackage

// File: rtl/pktport_ram.sv
`timescale 1ns/1ps
// Byte buffer with one synchronous write port and one asynchronous read port.
// Assumes the caller keeps write addresses below DEPTH.
module pktport_ram #(
    parameter int DEPTH = 1514,
    parameter int AW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    // Store one byte per enabled cycle.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/pktport_txstream.sv
`timescale 1ns/1ps
// Streams a stored frame of len bytes out with valid/last handshaking.
// Assumes start only pulses while idle and len is nonzero; abort wins.
module pktport_txstream #(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          abort,
    input  logic          start,
    input  logic [CW-1:0] len,
    input  logic          ready,
    output logic          active,
    output logic          last,
    output logic [CW-1:0] ptr
);
    localparam logic [CW-1:0] ONE = CW'(1);
    logic [CW-1:0] len_q;

    assign last = active && (ptr == len_q - ONE);

    // Track the byte being offered and the frame length.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            active <= 1'b0;
            ptr    <= '0;
            len_q  <= '0;
        end else if (start) begin
            active <= 1'b1;
            ptr    <= '0;
            len_q  <= len;
        end else if (active && ready) begin
            if (last) active <= 1'b0;
            else      ptr    <= ptr + ONE;
        end
    end
endmodule

// File: rtl/pktport.sv
`timescale 1ns/1ps
// Polled byte-port packet interface: register decode, receive and transmit
// counters, flag/busy logic and soft reset around two single-frame buffers.
// Assumes at most one host access per cycle and upstream holding rx bytes
// until rx_ready is high.
module pktport
    import pktport_pkg::*;
#(
    parameter int MAX_FRAME = 1514
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_sel,
    input  logic        host_wr,
    input  logic [5:0]  host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_last,
    output logic        rx_ready,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    input  logic        tx_ready,
    output logic        irq
);
    localparam int            CW    = $clog2(MAX_FRAME + 1);
    localparam logic [CW-1:0] MAX_C = CW'(MAX_FRAME);
    localparam logic [CW-1:0] ONE   = CW'(1);

    ictl_t         ictl, ictl_n;
    logic          busy, busy_n;
    logic          in_frame;
    logic [CW-1:0] rx_count, rd_ptr, tx_count, tx_written, tx_ptr;
    logic [7:0]    rx_byte;

    // Access decode.
    logic rd, wr, wr_ictl, wr_txcnt, soft_rst, rd_ictl;
    assign rd       = host_sel && !host_wr;
    assign wr       = host_sel && host_wr;
    assign wr_ictl  = wr && (host_addr == OFS_ICTL);
    assign wr_txcnt = wr && (host_addr == OFS_TXCNT);
    assign rd_ictl  = rd && (host_addr == OFS_ICTL);
    assign soft_rst = wr_ictl && !host_wdata[0] && !host_wdata[1] && host_wdata[31];

    // Receive side events.
    logic rx_take, rx_first, rx_store, rx_rd_hit;
    assign rx_ready  = in_frame || (!busy && (rx_count < MAX_C));
    assign rx_take   = rx_valid && rx_ready;
    assign rx_first  = rx_take && !in_frame;
    assign rx_store  = rx_take && (!in_frame || (rx_count < MAX_C));
    assign rx_rd_hit = rd && (host_addr == OFS_RXDAT) && (rx_count != '0) && !in_frame;

    // Transmit side events.
    logic tx_wr_ok, tx_done_now;
    assign tx_wr_ok    = wr && (host_addr == OFS_TXDAT) && !tx_valid && (tx_count != '0);
    assign tx_done_now = tx_wr_ok && ((tx_written + ONE) == tx_count);

    assign irq = ictl.txd || ictl.rxd || ictl.test;

    // Next flag set and busy from host access plus stream events.
    always_comb begin
        ictl_n = ictl;
        busy_n = busy;
        if (rd_ictl) ictl_n.test = 1'b0;
        if (wr_ictl) begin
            if (host_wdata[0])      ictl_n.txd = 1'b0;
            else if (host_wdata[1]) ictl_n.rxd = 1'b0;
            busy_n = ictl_n.txd || ictl_n.rxd || ictl_n.test;
        end
        if (tx_done_now) begin
            ictl_n.txd = 1'b1;
            busy_n     = 1'b1;
        end
        if (rx_first) busy_n = 1'b1;
        if (rx_take && rx_last) begin
            ictl_n.rxd = 1'b1;
            busy_n     = 1'b1;
        end
    end

    // Control state: flags, busy, counters and pointers.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            ictl       <= '{test: soft_rst, rxd: 1'b0, txd: 1'b0};
            busy       <= 1'b1;
            in_frame   <= 1'b0;
            rx_count   <= '0;
            rd_ptr     <= '0;
            tx_count   <= '0;
            tx_written <= '0;
        end else begin
            ictl <= ictl_n;
            busy <= busy_n;
            if (rx_take) in_frame <= !rx_last;
            if (rx_first) begin
                rx_count <= ONE;
                rd_ptr   <= '0;
            end else if (rx_take) begin
                if (rx_count < MAX_C) rx_count <= rx_count + ONE;
            end else if (rx_rd_hit) begin
                rx_count <= rx_count - ONE;
                rd_ptr   <= rd_ptr + ONE;
            end
            if (wr_txcnt) begin
                tx_count   <= (host_wdata <= 32'(MAX_FRAME)) ? host_wdata[CW-1:0] : '0;
                tx_written <= '0;
            end else if (tx_done_now) begin
                tx_count   <= '0;
                tx_written <= '0;
            end else if (tx_wr_ok) begin
                tx_written <= tx_written + ONE;
            end
        end
    end

    // Registered read data; holds between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata <= '0;
        end else if (rd) begin
            case (host_addr)
                OFS_ID0:   host_rdata <= ID_WORD0;
                OFS_ID1:   host_rdata <= ID_WORD1;
                OFS_BUSY:  host_rdata <= {31'd0, busy};
                OFS_RXCNT: host_rdata <= {{(32-CW){1'b0}}, rx_count};
                OFS_TXCNT: host_rdata <= {{(32-CW){1'b0}}, tx_count};
                OFS_ICTL:  host_rdata <= ictl_word(ictl);
                OFS_RXDAT: host_rdata <= rx_rd_hit ? {24'd0, rx_byte} : 32'd0;
                default:   host_rdata <= 32'd0;
            endcase
        end
    end

    pktport_ram #(.DEPTH(MAX_FRAME), .AW(CW)) u_rxbuf (
        .clk   (clk),
        .we    (rx_store),
        .waddr (in_frame ? rx_count : '0),
        .wdata (rx_data),
        .raddr (rd_ptr),
        .rdata (rx_byte)
    );

    pktport_ram #(.DEPTH(MAX_FRAME), .AW(CW)) u_txbuf (
        .clk   (clk),
        .we    (tx_wr_ok),
        .waddr (tx_written),
        .wdata (host_wdata[7:0]),
        .raddr (tx_ptr),
        .rdata (tx_data)
    );

    pktport_txstream #(.CW(CW)) u_txs (
        .clk    (clk),
        .rst_n  (rst_n),
        .abort  (soft_rst),
        .start  (tx_done_now),
        .len    (tx_count),
        .ready  (tx_ready),
        .active (tx_valid),
        .last   (tx_last),
        .ptr    (tx_ptr)
    );
endmodule

// File: rtl/pktport_chk.sv
`timescale 1ns/1ps
// Property checker for pktport, attached by bind below.
// Assumes it sees the top's ports and its flag, busy and counter state.
module pktport_chk
    import pktport_pkg::*;
#(
    parameter int MAX_FRAME = 1514,
    parameter int CW        = $clog2(MAX_FRAME + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_sel,
    input logic          host_wr,
    input logic [5:0]    host_addr,
    input logic [31:0]   host_wdata,
    input logic          rx_valid,
    input logic          rx_ready,
    input logic          rx_last,
    input logic          tx_valid,
    input logic          tx_ready,
    input logic [7:0]    tx_data,
    input logic          tx_last,
    input logic          irq,
    input ictl_t         ictl,
    input logic          busy,
    input logic          in_frame,
    input logic [CW-1:0] rx_count,
    input logic [CW-1:0] tx_count
);
    logic hw, sr;
    assign hw = host_sel && host_wr;
    assign sr = hw && (host_addr == OFS_ICTL) && !host_wdata[0] && !host_wdata[1] && host_wdata[31];

    a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && rx_last && !sr) |=> (irq && ictl.rxd));

    a_r6_gate_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_frame && busy) |-> !rx_ready);

    a_r4_tx_clear_first: assert property (@(posedge clk) disable iff (!rst_n)
        (hw && (host_addr == OFS_ICTL) && host_wdata[0]) |=> !ictl.txd);

    a_r5_selftest: assert property (@(posedge clk) disable iff (!rst_n)
        sr |=> (ictl.test && !ictl.rxd && !ictl.txd && busy && (rx_count == '0) && !tx_valid));

    a_r11_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !sr) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    a_r10_start_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> $past(hw && (host_addr == OFS_TXDAT)));

    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= CW'(MAX_FRAME));

    a_r9_clip_length: assert property (@(posedge clk) disable iff (!rst_n)
        (hw && (host_addr == OFS_TXCNT) && (host_wdata > 32'(MAX_FRAME))) |=> (tx_count == '0));

    a_r3_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past((rx_valid && rx_ready && rx_last) || hw));
endmodule

bind pktport pktport_chk #(.MAX_FRAME(MAX_FRAME)) u_chk (.*);

// File: tb/sim_pktport.sv
`timescale 1ns/1ps
// Directed bench for pktport: one task per scenario, each checking itself.
module sim_pktport;
    localparam int MAXF = 1514;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_sel = 1'b0, host_wr = 1'b0;
    logic [5:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        rx_valid = 1'b0, rx_last = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready;
    logic        tx_valid, tx_last;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;
    logic        irq;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    pktport #(.MAX_FRAME(MAXF)) u0 (.*);

    always #5 clk = ~clk;

    function automatic logic [7:0] pat(input logic [7:0] s, input int i);
        return s + 8'(i * 17);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hwrite(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_sel = 1'b0; host_wr = 1'b0;
    endtask

    task automatic hread(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b0; host_addr = a;
        @(negedge clk);
        host_sel = 1'b0;
        d = host_rdata;
    endtask

    task automatic rcheck(input string tag, input logic [5:0] a, input logic [31:0] exp);
        logic [31:0] v;
        hread(a, v);
        check(tag, v, exp);
    endtask

    // Offer n bytes on the receive stream, waiting for ready on each.
    task automatic rx_send(input int n, input logic [7:0] s);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = pat(s, i); rx_last = (i == n - 1);
            while (!rx_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    // Collect n outgoing bytes and compare; optional stalls on ready.
    task automatic tx_collect(input string tag, input int n, input logic [7:0] s, input bit stall);
        int got = 0;
        int guard = 0;
        while (got < n && guard < 4000) begin
            @(negedge clk);
            guard++;
            tx_ready = stall ? guard[0] : 1'b1;
            if (tx_valid && tx_ready) begin
                check({tag, " data"}, {24'd0, tx_data}, {24'd0, pat(s, got)});
                check({tag, " last"}, {31'd0, tx_last}, {31'd0, (got == n - 1)});
                got++;
                @(posedge clk);
            end
        end
        check({tag, " count"}, got, n);
        @(negedge clk);
        tx_ready = 1'b0;
        check({tag, " idle after frame"}, {31'd0, tx_valid}, 32'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R2 irq", {31'd0, irq}, 32'd0);
        check("R2 rx_ready", {31'd0, rx_ready}, 32'd0);
        rcheck("R2 busy", 6'h08, 32'd1);
        rcheck("R2 ictl", 6'h14, 32'd0);
        rcheck("R2 rx count", 6'h0c, 32'd0);
        rcheck("R2 tx count", 6'h10, 32'd0);
    endtask

    task automatic t_ident();
        rcheck("R1 id0", 6'h00, 32'h4259_5445);
        rcheck("R1 id1", 6'h04, 32'h5052_5431);
        rcheck("R1 info", 6'h18, 32'd0);
        rcheck("R1 tx data reads 0", 6'h20, 32'd0);
        rcheck("R1 unmapped 0x24", 6'h24, 32'd0);
        rcheck("R1 unmapped 0x3c", 6'h3c, 32'd0);
        hwrite(6'h08, 32'd0);
        rcheck("R1 busy write ignored", 6'h08, 32'd1);
        hwrite(6'h0c, 32'd9);
        rcheck("R1 rx count write ignored", 6'h0c, 32'd0);
    endtask

    task automatic t_unbusy();
        hwrite(6'h14, 32'd0);
        rcheck("R4 zero write clears busy", 6'h08, 32'd0);
        check("R6 ready when idle", {31'd0, rx_ready}, 32'd1);
        check("R3 irq low", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_rx();
        logic [31:0] v;
        rx_send(5, 8'h30);
        check("R7 irq after frame", {31'd0, irq}, 32'd1);
        check("R6 ready gated by busy", {31'd0, rx_ready}, 32'd0);
        rcheck("R7 rx count", 6'h0c, 32'd5);
        rcheck("R3 rx done bit 1", 6'h14, 32'd2);
        rcheck("R7 busy", 6'h08, 32'd1);
        for (int i = 0; i < 5; i++) begin
            hread(6'h1c, v);
            check("R8 rx byte", v, {24'd0, pat(8'h30, i)});
            rcheck("R8 count down", 6'h0c, 32'(4 - i));
        end
        rcheck("R8 empty read 0", 6'h1c, 32'd0);
        rcheck("R8 empty count stays", 6'h0c, 32'd0);
        hwrite(6'h14, 32'd2);
        rcheck("R4 rx done cleared", 6'h14, 32'd0);
        rcheck("R4 busy after clear", 6'h08, 32'd0);
        check("R3 irq cleared", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_tx();
        hwrite(6'h10, 32'd4);
        rcheck("R9 tx count loaded", 6'h10, 32'd4);
        for (int i = 0; i < 4; i++) hwrite(6'h20, {24'hABCDEF, pat(8'h50, i)});
        check("R11 valid after last write", {31'd0, tx_valid}, 32'd1);
        tx_collect("R11 frame", 4, 8'h50, 1'b0);
        rcheck("R10 tx done", 6'h14, 32'd1);
        rcheck("R10 busy", 6'h08, 32'd1);
        rcheck("R10 count cleared", 6'h10, 32'd0);
        check("R3 irq tx", {31'd0, irq}, 32'd1);
    endtask

    task automatic t_priority();
        hwrite(6'h14, 32'd1);
        rcheck("R4 tx done cleared", 6'h14, 32'd0);
        rx_send(1, 8'h77);
        rcheck("R7 single byte count", 6'h0c, 32'd1);
        hwrite(6'h10, 32'd1);
        hwrite(6'h20, 32'h66);
        tx_collect("R11 stalled frame", 1, 8'h66, 1'b1);
        rcheck("R3 both flags", 6'h14, 32'd3);
        hwrite(6'h14, 32'd3);
        rcheck("R4 bit 0 wins", 6'h14, 32'd2);
        rcheck("R4 busy stays", 6'h08, 32'd1);
        hwrite(6'h14, 32'd2);
        rcheck("R4 all clear busy", 6'h08, 32'd0);
    endtask

    task automatic t_txcount();
        hwrite(6'h10, 32'd1515);
        rcheck("R9 over limit loads 0", 6'h10, 32'd0);
        hwrite(6'h10, 32'd1514);
        rcheck("R9 at limit", 6'h10, 32'd1514);
        hwrite(6'h10, 32'd3);
        hwrite(6'h20, 32'h5A);
        hwrite(6'h10, 32'd2);
        hwrite(6'h20, {24'd0, pat(8'h70, 0)});
        hwrite(6'h20, {24'd0, pat(8'h70, 1)});
        tx_collect("R9 restart written counter", 2, 8'h70, 1'b0);
        hwrite(6'h14, 32'd1);
    endtask

    task automatic t_ignore();
        hwrite(6'h10, 32'd3);
        for (int i = 0; i < 3; i++) hwrite(6'h20, {24'd0, pat(8'h10, i)});
        check("R11 holding", {31'd0, tx_valid}, 32'd1);
        hwrite(6'h10, 32'd2);
        hwrite(6'h20, 32'h11);
        tx_collect("R11 first frame", 3, 8'h10, 1'b1);
        hwrite(6'h20, 32'h22);
        check("R11 ignored write not counted", {31'd0, tx_valid}, 32'd0);
        hwrite(6'h20, 32'h33);
        tx_collect("R11 second frame", 2, 8'h22, 1'b0);
        hwrite(6'h14, 32'd1);
        hwrite(6'h20, 32'h99);
        @(negedge clk);
        check("R11 zero count write ignored", {31'd0, tx_valid}, 32'd0);
        rcheck("R11 no tx done", 6'h14, 32'd0);
    endtask

    task automatic t_full();
        logic [31:0] v;
        rcheck("R8 leftover byte", 6'h1c, {24'd0, pat(8'h77, 0)});
        rx_send(MAXF, 8'h03);
        rcheck("R7 full count", 6'h0c, 32'd1514);
        hwrite(6'h14, 32'd2);
        rcheck("R6 busy clear at full", 6'h08, 32'd0);
        check("R6 full blocks ready", {31'd0, rx_ready}, 32'd0);
        hread(6'h1c, v);
        check("R8 first of full frame", v, {24'd0, pat(8'h03, 0)});
        rcheck("R8 count 1513", 6'h0c, 32'd1513);
        check("R6 below limit ready", {31'd0, rx_ready}, 32'd1);
    endtask

    task automatic t_selftest();
        hwrite(6'h10, 32'd7);
        hwrite(6'h14, 32'h8000_0000);
        check("R5 irq from test", {31'd0, irq}, 32'd1);
        rcheck("R5 rx count reset", 6'h0c, 32'd0);
        rcheck("R5 tx count reset", 6'h10, 32'd0);
        rcheck("R5 busy", 6'h08, 32'd1);
        rcheck("R5 test bit 31", 6'h14, 32'h8000_0000);
        rcheck("R5 cleared on read", 6'h14, 32'd0);
        check("R3 irq after read", {31'd0, irq}, 32'd0);
        check("R6 still gated", {31'd0, rx_ready}, 32'd0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ident();
        t_unbusy();
        t_rx();
        t_tx();
        t_priority();
        t_txcount();
        t_ignore();
        t_full();
        t_selftest();
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R2 watchdog actual=running expected=done");
            summary();
            $finish;
        end
    end
endmodule